// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

This block is an 8-bit up-counter that advances on ticks from an internal prescaler. One control bit picks what an overflow means. In interval mode, the rollover from 0xFF to 0x00 sets a sticky flag, and the CPU sees that flag as an interrupt request. In watchdog mode, the same rollover emits a one-cycle pulse on an external overflow pin, and the flag is left alone.

Software reads the control/status byte with ordinary reads. A write only takes effect when it is a 16-bit word whose upper byte is the key 0xA5. The flag has its own clearing sequence: a read must first see the flag as 1, and then a keyed write must carry 0 in that bit.

A standby input turns off counting and clears the mode bit and the flag. The clock selection survives standby.

There is no data stream through this block. Every pin is a plain control or status signal, so no valid/ready handshake and no back-pressure apply.

Top module: `gtmr_top`

## Requirements
- R1: After reset, `bus_rdata` reads 0x18, `irq_o` is 0 and `wdog_ovf_o` is 0. The byte layout is: bit 7 flag, bit 6 mode (1 = watchdog), bit 5 run, bits 4..3 constant 1, bits 2..0 clock select.
- R2: A write is accepted only when `bus_wr` is high, `bus_wdata[15:8]` equals 0xA5 and `standby` is low. An accepted write loads mode, run and select from `bus_wdata[6]`, `bus_wdata[5]` and `bus_wdata[2:0]`. Any other write leaves bits 6..0 unchanged. Bits 4..3 always read 1.
- R3: The counter and the prescaler advance only while run is 1. A cycle with run at 0 returns both of them to zero, so the next overflow is measured from the moment run is set again.
- R4: The prescaler divides the clock by 2, 64, 128, 256, 512, 1024, 4096 or 8192 for select codes 0 to 7. An overflow therefore comes 256 times that ratio in cycles after run is set.
- R5: In interval mode, an overflow sets the flag. `irq_o` is high exactly while the flag is 1 and the mode is interval.
- R6: The flag is cleared only by an accepted write with `bus_wdata[7]` at 0 that follows a read (`bus_rd` high) which saw the flag at 1. The sequence also requires that no accepted write came between that read and the clearing write. Writing 1, or writing 0 without that read, leaves the flag set.
- R7: In watchdog mode, every overflow drives `wdog_ovf_o` high for exactly one cycle, in the cycle after the overflow. The flag is never set in this mode.
- R8: While `standby` is high, the flag, mode and run are forced to 0 and the clock select keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Standby request; clears flag, mode and run |
| bus_wr | input | 1 | Write strobe for a 16-bit keyed write |
| bus_rd | input | 1 | Read strobe; arms flag clearing |
| bus_wdata | input | 16 | Key in bits 15..8, new value in bits 7..0 |
| bus_rdata | output | 8 | Current control/status byte |
| irq_o | output | 1 | Interval interrupt request |
| wdog_ovf_o | output | 1 | One-cycle watchdog overflow pulse |

## Verification
The hardest case to reach is a long overflow at the higher clock-select codes, because one overflow costs up to two million cycles. The bench therefore times overflows directly for select codes 0, 1 and 2 only, and relies on the shared prescaler structure for the other codes.

A second hard case is a restart of the count part-way through an interval. To reach it, the bench drops run for a single cycle at mid-count and then shows that the flag stays low past the point where an unbroken count would have overflowed.

The flag-clearing protocol is reached by chaining sequences that must fail before one that succeeds:
- a write of 0 with no read before it;
- a write of 1 after a read;
- a read followed by a correct write of 0.

Throughout all of this, a behavioural model runs alongside the design and compares all outputs on every cycle.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int unsigned SEL_W = 3;

  // Bit layout of the control/status byte.
  typedef struct packed {
    logic             flag;
    logic             wdog_mode;
    logic             run;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  // Base-2 logarithm of the prescaler ratio chosen by each select code.
  function automatic int unsigned sel_shift(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 6;
      3'd2:    return 7;
      3'd3:    return 8;
      3'd4:    return 9;
      3'd5:    return 10;
      3'd6:    return 12;
      default: return 13;
    endcase
  endfunction
endpackage

// File: rtl/gtmr_prescaler.sv
module gtmr_prescaler #(
  parameter int unsigned PSC_W = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic [gtmr_pkg::SEL_W-1:0] sel,
  output logic                      tick
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PSC_W; i++) begin
      if (i < int'(gtmr_pkg::sel_shift(sel))) mask[i] = 1'b1;
    end
  end

  assign tick = run && ((psc_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)   psc_q <= '0;
    else if (run) psc_q <= psc_q + 1'b1;
    else          psc_q <= '0;
  end
endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic ovf
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  assign ovf = tick && (cnt_q == CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/gtmr_ctrl.sv
module gtmr_ctrl #(
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [15:0]      bus_wdata,
  input  logic             ovf,
  output gtmr_pkg::ctl_t   ctl,
  output logic             wdog_pulse
);
  gtmr_pkg::ctl_t ctl_q;
  logic           arm_q;
  logic           wr_ok;

  assign wr_ok = bus_wr && (bus_wdata[15:8] == KEY) && !standby;
  assign ctl   = ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      arm_q      <= 1'b0;
      wdog_pulse <= 1'b0;
    end else begin
      wdog_pulse <= ovf && ctl_q.wdog_mode;
      if (standby) begin
        ctl_q.flag      <= 1'b0;
        ctl_q.wdog_mode <= 1'b0;
        ctl_q.run       <= 1'b0;
        arm_q           <= 1'b0;
      end else begin
        if (wr_ok) begin
          ctl_q.wdog_mode <= bus_wdata[6];
          ctl_q.run       <= bus_wdata[5];
          ctl_q.sel       <= bus_wdata[2:0];
        end
        if (wr_ok)                      arm_q <= 1'b0;
        else if (bus_rd && ctl_q.flag)  arm_q <= 1'b1;
        if (ovf && !ctl_q.wdog_mode)                 ctl_q.flag <= 1'b1;
        else if (wr_ok && arm_q && !bus_wdata[7])    ctl_q.flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PSC_W = 13,
  parameter logic [7:0]  KEY   = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        standby,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        irq_o,
  output logic        wdog_ovf_o
);
  gtmr_pkg::ctl_t ctl;
  logic tick, ovf;

  gtmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .sel(ctl.sel), .tick(tick));

  gtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .tick(tick), .ovf(ovf));

  gtmr_ctrl #(.KEY(KEY)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .standby(standby), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .ovf(ovf), .ctl(ctl),
    .wdog_pulse(wdog_ovf_o));

  assign bus_rdata = {ctl.flag, ctl.wdog_mode, ctl.run, 2'b11, ctl.sel};
  assign irq_o     = ctl.flag && !ctl.wdog_mode;
endmodule

// File: rtl/gtmr_checker.sv
module gtmr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        standby,
  input logic        bus_wr,
  input logic [15:0] bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        irq_o,
  input logic        wdog_ovf_o
);
  // R7
  wdog_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_ovf_o |=> !wdog_ovf_o);
  // R7
  no_flag_in_wdog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rdata[7]) |-> !$past(bus_rdata[6]));
  // R5
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> bus_rdata[7]);
  // R2
  bad_key_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[15:8] != 8'hA5 && !standby) |=> $stable(bus_rdata[6:0]));
  // R8
  standby_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (bus_rdata[7:5] == 3'b000));
  // R8
  standby_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> $stable(bus_rdata[2:0]));
  // R6
  flag_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rdata[7]) |-> ($past(standby) ||
      $past(bus_wr && bus_wdata[15:8] == 8'hA5 && !bus_wdata[7])));
endmodule

bind gtmr_top gtmr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
  .wdog_ovf_o(wdog_ovf_o));

// File: tb/tb_gtmr_top.sv
module tb_gtmr_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0, standby = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_o, wdog_ovf_o;

  always #10 clk = ~clk;

  gtmr_top dut (.clk(clk), .rst_n(rst_n), .standby(standby), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wdog_ovf_o(wdog_ovf_o));

  int vectors = 0, errors = 0, pulses = 0, cycles = 0;
  bit done = 0;

  // Behavioural reference model
  int divs[8] = '{2, 64, 128, 256, 512, 1024, 4096, 8192};
  int m_flag, m_mode, m_en, m_cks, m_psc, m_cnt, m_arm, m_wd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = 0; m_mode = 0; m_en = 0; m_cks = 0; m_psc = 0; m_cnt = 0; m_arm = 0; m_wd = 0;
    end else begin
      int tick, ov, key_ok, old_flag;
      tick = (m_en != 0) && ((m_psc % divs[m_cks]) == divs[m_cks] - 1);
      ov = tick && (m_cnt == 255);
      old_flag = m_flag;
      key_ok = bus_wr && (bus_wdata[15:8] == 8'hA5) && !standby;
      m_wd = ov && m_mode;
      if (m_en == 0) begin m_psc = 0; m_cnt = 0; end
      else begin
        m_psc = m_psc + 1;
        if (tick) m_cnt = (m_cnt + 1) % 256;
      end
      if (standby) begin
        m_flag = 0; m_mode = 0; m_en = 0; m_arm = 0;
      end else begin
        if (ov && m_mode == 0) m_flag = 1;
        else if (key_ok && m_arm && !bus_wdata[7]) m_flag = 0;
        if (key_ok) m_arm = 0;
        else if (bus_rd && old_flag) m_arm = 1;
        if (key_ok) begin
          m_mode = bus_wdata[6]; m_en = bus_wdata[5]; m_cks = bus_wdata[2:0];
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Compare every cycle against the model
  always @(negedge clk) begin
    cycles++;
    if (wdog_ovf_o) pulses++;
    check(bus_rdata == {m_flag[0], m_mode[0], m_en[0], 2'b11, m_cks[2:0]},
          "R2/R5/R8 rdata", bus_rdata, {m_flag[0], m_mode[0], m_en[0], 2'b11, m_cks[2:0]});
    check(irq_o == (m_flag != 0 && m_mode == 0), "R5 irq", irq_o, (m_flag != 0 && m_mode == 0));
    check(wdog_ovf_o == (m_wd != 0), "R7 wdog", wdog_ovf_o, m_wd);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic [7:0] key, input logic [7:0] val);
    @(negedge clk); bus_wr = 1'b1; bus_wdata = {key, val};
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask
  task automatic rd();
    @(negedge clk); bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask
  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; idle(3); rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    idle(1);
    check(bus_rdata == 8'h18 && !irq_o && !wdog_ovf_o, "R1 reset", bus_rdata, 8'h18);

    wr(8'h5A, 8'h27);
    check(bus_rdata == 8'h18, "R2 bad key ignored", bus_rdata, 8'h18);
    wr(8'hA5, 8'h23);
    check(bus_rdata == 8'h3B, "R2 keyed write", bus_rdata, 8'h3B);
    wr(8'hA5, 8'h00);

    // R5: interval overflow at select 0 (512 cycles)
    wr(8'hA5, 8'h20);
    idle(600);
    check(bus_rdata[7] && irq_o, "R5 flag and irq", {bus_rdata[7], irq_o}, 3);
    // R6: clear sequences
    wr(8'hA5, 8'h20);
    check(bus_rdata[7] == 1'b1, "R6 clear without read", bus_rdata[7], 1);
    rd(); wr(8'hA5, 8'hA0);
    check(bus_rdata[7] == 1'b1, "R6 write one", bus_rdata[7], 1);
    rd(); wr(8'hA5, 8'h20);
    check(bus_rdata[7] == 1'b0 && !irq_o, "R6 proper clear", bus_rdata[7], 0);

    // R8: standby
    wr(8'hA5, 8'h25);
    @(negedge clk); standby = 1'b1; bus_wr = 1'b1; bus_wdata = 16'hA527;
    @(negedge clk); standby = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    check(bus_rdata == 8'h1D, "R8 standby", bus_rdata, 8'h1D);

    // R7: watchdog mode, two overflows within 1100 cycles
    do_reset();
    pulses = 0;
    wr(8'hA5, 8'h60);
    idle(1100);
    check(pulses == 2, "R7 pulse count", pulses, 2);
    check(bus_rdata[7] == 1'b0 && !irq_o, "R7 no flag", bus_rdata[7], 0);

    // R3: brief disable restarts the count
    do_reset();
    wr(8'hA5, 8'h20);
    idle(300);
    wr(8'hA5, 8'h00);
    wr(8'hA5, 8'h20);
    idle(400);
    check(bus_rdata[7] == 1'b0, "R3 restart delays flag", bus_rdata[7], 0);
    idle(200);
    check(bus_rdata[7] == 1'b1, "R3 flag after restart", bus_rdata[7], 1);

    // R4: select 1 and 2 timing
    do_reset();
    wr(8'hA5, 8'h21);
    idle(16370);
    check(bus_rdata[7] == 1'b0, "R4 sel1 early", bus_rdata[7], 0);
    idle(30);
    check(bus_rdata[7] == 1'b1, "R4 sel1 due", bus_rdata[7], 1);
    do_reset();
    wr(8'hA5, 8'h22);
    idle(32750);
    check(bus_rdata[7] == 1'b0, "R4 sel2 early", bus_rdata[7], 0);
    idle(30);
    check(bus_rdata[7] == 1'b1, "R4 sel2 due", bus_rdata[7], 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        vectors++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule